// File: doc/BRIEF.md
# Event-Stepped I2C Bus Master

This block is an I2C bus master that moves one protocol step at a time. Software sets a start request. The block then waits until both bus lines are high and issues a START condition. After that, every step ends the same way: the block loads a byte-wide status code, raises an event flag, and parks the bus with SCL pulled low. Nothing further happens on the bus until software clears the flag. Software reads the code and decides the next action. It either loads the next byte into the data register or requests a STOP.

The first byte after START is the target address in the upper seven bits, with the direction in bit 0. A 0 in bit 0 selects a write and a 1 selects a read. After a write address, the following bytes go out from the data register. After a read address, bytes are shifted in and land in the data register. The master then answers each received byte with an acknowledge or a not-acknowledge, as set by the acknowledge-enable input.

Both bus lines are open-drain. A drive output of 1 pulls the line low. The SCL rate is set by a parameterized divider of the system clock, with equal high and low phases.

Top module: `stepped_i2c_master`

## Requirements
- R1: After reset the status reads F8h, the event flag is 0, both start and stop requests are 0, and neither bus line is pulled low.
- R2: A pending start request issues a START (SDA falls while SCL is high) only while both lines are seen high. When the START completes, the flag rises with status 08h and the start request clears.
- R3: Once the flag is cleared after 08h, the data register is sent MSB first and bit 0 becomes the direction. With bit 0 = 0, the status is 18h if the target pulls SDA low in the ninth clock, and 20h if it leaves SDA high.
- R4: With address bit 0 = 1, the status is 40h on acknowledge and 48h on not-acknowledge.
- R5: In a write transfer, each further data byte is sent MSB first and reports 28h on acknowledge and 30h on not-acknowledge.
- R6: In a read transfer, eight bits are shifted in MSB first and placed in the data register. The master pulls SDA low in the ninth clock when acknowledge-enable is 1 and releases it when it is 0. The status is then 50h or 58h respectively.
- R7: While the flag is set, SCL stays pulled low and neither line changes, until software clears the flag.
- R8: If the master releases SDA for a bit but sees it low at the end of the SCL high phase, it releases both lines. The flag then rises with status 38h.
- R9: A stop request with the flag cleared produces a STOP (SDA rises while SCL is high). The stop request then clears itself and both lines are left released.
- R10: During a byte, every SCL high phase and every SCL low phase lasts HALF_PERIOD system clocks.
- R11: Whenever the flag is 0, the status reads F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_start | input | 1 | Pulse: raise the start request |
| set_stop | input | 1 | Pulse: raise the stop request |
| clr_flag | input | 1 | Pulse: clear the event flag and let the bus proceed |
| ack_en | input | 1 | 1: acknowledge received bytes; 0: not-acknowledge |
| wr_en | input | 1 | Pulse: load wr_data into the data register |
| wr_data | input | 8 | Byte for the data register |
| rd_data | output | 8 | Data register contents (last received byte in read mode) |
| status | output | 8 | Status code of the last event, F8h while the flag is 0 |
| irq_flag | output | 1 | Event flag; the bus is parked while it is 1 |
| start_pending | output | 1 | Start request still waiting |
| stop_pending | output | 1 | Stop request still waiting |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong step in the control state shows up at the next event as an unexpected status code, normally within one byte time (18 SCL half-periods). A corrupted shift register shows up as a wrong byte at the target, or as a wrong value in the data register after a read. A broken stall shows within one half-period, as SCL rising while the flag is still set. A lost START or STOP shows as a missing line edge, or as a request bit that never clears.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START_A,
        PH_START_B,
        PH_HOLD,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_ACK_LO,
        PH_ACK_HI,
        PH_STOP_A,
        PH_STOP_B,
        PH_STOP_C
    } phase_e;

    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_WA_ACK    = 8'h18;
    localparam logic [7:0] ST_WA_NACK   = 8'h20;
    localparam logic [7:0] ST_WD_ACK    = 8'h28;
    localparam logic [7:0] ST_WD_NACK   = 8'h30;
    localparam logic [7:0] ST_ARB_LOST  = 8'h38;
    localparam logic [7:0] ST_RA_ACK    = 8'h40;
    localparam logic [7:0] ST_RA_NACK   = 8'h48;
    localparam logic [7:0] ST_RD_ACK    = 8'h50;
    localparam logic [7:0] ST_RD_NACK   = 8'h58;
    localparam logic [7:0] ST_NONE      = 8'hF8;

    // Status code after the ninth clock of a byte.
    function automatic logic [7:0] ack_status(input logic addr_byte,
                                              input logic rd,
                                              input logic nack);
        if (addr_byte)
            return rd ? (nack ? ST_RA_NACK : ST_RA_ACK)
                      : (nack ? ST_WA_NACK : ST_WA_ACK);
        return rd ? (nack ? ST_RD_NACK : ST_RD_ACK)
                  : (nack ? ST_WD_NACK : ST_WD_ACK);
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/i2cs_tick_gen.sv
module i2cs_tick_gen #(
    parameter int HALF_PERIOD = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/stepped_i2c_master.sv
module stepped_i2c_master
    import i2cs_pkg::*;
#(
    parameter int HALF_PERIOD = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_start,
    input  logic       set_stop,
    input  logic       clr_flag,
    input  logic       ack_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       irq_flag,
    output logic       start_pending,
    output logic       stop_pending,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic scl_s, sda_s, tick;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));
    i2cs_tick_gen #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk(clk), .rst(rst), .tick(tick));

    phase_e     st;
    logic [7:0] sh, dat_q, code_q;
    logic [2:0] bitn;
    logic       first_q, rx_q, flag_q, start_q, stop_q;
    logic       scl_drv, sda_drv, sda_dly;
    logic       xmit;

    // The master drives SDA with data when it sends the address or any write byte.
    assign xmit = first_q || !rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            sh      <= '0;
            dat_q   <= '0;
            code_q  <= ST_NONE;
            bitn    <= '0;
            first_q <= 1'b0;
            rx_q    <= 1'b0;
            flag_q  <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            scl_drv <= 1'b0;
            sda_drv <= 1'b0;
            sda_dly <= 1'b0;
        end else begin
            sda_dly <= sda_drv;
            if (set_start) start_q <= 1'b1;
            if (set_stop)  stop_q  <= 1'b1;
            if (clr_flag)  flag_q  <= 1'b0;
            if (wr_en)     dat_q   <= wr_data;

            case (st)
                PH_IDLE: begin
                    if (stop_q) stop_q <= 1'b0;
                    if (tick && start_q && !flag_q && scl_s && sda_s) begin
                        st      <= PH_START_A;
                        sda_drv <= 1'b1;
                    end
                end
                PH_START_A: if (tick) begin
                    st      <= PH_START_B;
                    scl_drv <= 1'b1;
                end
                PH_START_B: if (tick) begin
                    st      <= PH_HOLD;
                    start_q <= 1'b0;
                    flag_q  <= 1'b1;
                    code_q  <= ST_START;
                    first_q <= 1'b1;
                end
                PH_HOLD: if (tick && !flag_q) begin
                    if (stop_q) begin
                        st      <= PH_STOP_A;
                        sda_drv <= 1'b1;
                    end else begin
                        st   <= PH_BIT_LO;
                        bitn <= 3'd7;
                        sh   <= dat_q;
                        if (first_q) rx_q <= dat_q[0];
                        sda_drv <= (first_q || !rx_q) ? !dat_q[7] : 1'b0;
                    end
                end
                PH_BIT_LO: if (tick) begin
                    st      <= PH_BIT_HI;
                    scl_drv <= 1'b0;
                end
                PH_BIT_HI: if (tick) begin
                    if (xmit && !sda_drv && !sda_s) begin
                        st      <= PH_IDLE;
                        scl_drv <= 1'b0;
                        sda_drv <= 1'b0;
                        flag_q  <= 1'b1;
                        code_q  <= ST_ARB_LOST;
                        first_q <= 1'b0;
                    end else begin
                        sh      <= {sh[6:0], sda_s};
                        scl_drv <= 1'b1;
                        if (bitn == 3'd0) begin
                            st      <= PH_ACK_LO;
                            sda_drv <= xmit ? 1'b0 : ack_en;
                        end else begin
                            bitn    <= bitn - 1'b1;
                            st      <= PH_BIT_LO;
                            sda_drv <= xmit ? !sh[6] : 1'b0;
                        end
                    end
                end
                PH_ACK_LO: if (tick) begin
                    st      <= PH_ACK_HI;
                    scl_drv <= 1'b0;
                end
                PH_ACK_HI: if (tick) begin
                    st      <= PH_HOLD;
                    scl_drv <= 1'b1;
                    flag_q  <= 1'b1;
                    code_q  <= ack_status(first_q, rx_q, sda_s);
                    first_q <= 1'b0;
                    if (!xmit) dat_q <= sh;
                end
                PH_STOP_A: if (tick) begin
                    st      <= PH_STOP_B;
                    scl_drv <= 1'b0;
                end
                PH_STOP_B: if (tick) begin
                    st      <= PH_STOP_C;
                    sda_drv <= 1'b0;
                end
                PH_STOP_C: if (tick) begin
                    st     <= PH_IDLE;
                    stop_q <= 1'b0;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    assign scl_oe        = scl_drv;
    assign sda_oe        = sda_dly;
    assign irq_flag      = flag_q;
    assign status        = flag_q ? code_q : ST_NONE;
    assign rd_data       = dat_q;
    assign start_pending = start_q;
    assign stop_pending  = stop_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq_flag,
    input logic [7:0] status,
    input logic       start_pending,
    input logic       stop_pending
);
    assert_stall_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
        irq_flag && status != 8'h38 |-> scl_oe);

    assert_stall_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        irq_flag && $past(irq_flag) && status != 8'h38 |-> $stable(scl_oe) && $stable(sda_oe));

    assert_start_requested_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) && !scl_oe |-> $past(start_pending));

    assert_stop_requested_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) && !scl_oe |-> stop_pending || (irq_flag && status == 8'h38));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_pending) |-> !scl_oe && !sda_oe);

    assert_status_legal_R11: assert property (@(posedge clk) disable iff (rst)
        irq_flag |-> status inside {8'h08, 8'h18, 8'h20, 8'h28, 8'h30,
                                    8'h38, 8'h40, 8'h48, 8'h50, 8'h58});
endmodule

bind stepped_i2c_master i2cs_checker u_chk (
    .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq_flag(irq_flag), .status(status),
    .start_pending(start_pending), .stop_pending(stop_pending));

// File: tb/stepped_i2c_master_bench.sv
`timescale 1ns/1ps
module stepped_i2c_master_bench;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_start = 0, set_stop = 0, clr_flag = 0, ack_en = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, status;
    logic irq_flag, start_pending, stop_pending, scl_oe, sda_oe;
    logic slv_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_low);

    always #2.5 clk = ~clk;

    stepped_i2c_master #(.HALF_PERIOD(HALF)) u_stepped_i2c_master (
        .clk(clk), .rst(rst), .set_start(set_start), .set_stop(set_stop),
        .clr_flag(clr_flag), .ack_en(ack_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .status(status), .irq_flag(irq_flag),
        .start_pending(start_pending), .stop_pending(stop_pending),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

    int total = 0, bad = 0;
    int n_start = 0, n_stop = 0;
    time t_rise = 0, t_fall = 0, hi_w = 0, lo_w = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // bus condition and phase-width observers
    always @(negedge sda_line) if (scl_line) n_start++;
    always @(posedge sda_line) if (scl_line) n_stop++;
    always @(posedge scl_line) begin lo_w = $time - t_fall; t_rise = $time; end
    always @(negedge scl_line) begin hi_w = $time - t_rise; t_fall = $time; end

    // scoreboard monitor: each flag rise consumes one expected status
    always begin
        @(posedge irq_flag);
        @(negedge clk);
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected event", {24'h0, status}, 32'h0);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(status == e, t, {24'h0, status}, {24'h0, e});
        end
    end

    task automatic expect_status(input logic [7:0] code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic pulse_start(); @(negedge clk); set_start = 1; @(negedge clk); set_start = 0; endtask
    task automatic pulse_stop();  @(negedge clk); set_stop  = 1; @(negedge clk); set_stop  = 0; endtask
    task automatic pulse_clr();   @(negedge clk); clr_flag  = 1; @(negedge clk); clr_flag  = 0; endtask
    task automatic load(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
    endtask
    task automatic wait_irq(); wait (irq_flag == 1'b1); @(negedge clk); @(negedge clk); endtask

    // target receives a byte, answers ack (1) or nack (0)
    task automatic slave_rx(input bit ack, output logic [7:0] got);
        got = '0;
        pulse_clr();
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            got = {got[6:0], sda_line};
        end
        @(negedge scl_line); slv_low = ack;
        @(negedge scl_line); slv_low = 1'b0;
        wait_irq();
    endtask

    // target sends a byte, reports the master's ninth-bit level
    task automatic slave_tx(input logic [7:0] d, output logic mack);
        slv_low = !d[7];
        pulse_clr();
        for (int i = 7; i >= 0; i--) begin
            @(posedge scl_line);
            @(negedge scl_line);
            slv_low = (i > 0) ? !d[i-1] : 1'b0;
        end
        @(posedge scl_line); mack = sda_line;
        @(negedge scl_line);
        wait_irq();
    endtask

    task automatic do_start(input string tag);
        expect_status(8'h08, tag);
        pulse_start();
        wait_irq();
        chk(start_pending == 1'b0, "R2 start request clears", {31'h0, start_pending}, 32'h0);
    endtask

    task automatic do_stop();
        automatic int s0 = n_stop;
        pulse_stop();
        pulse_clr();
        wait (stop_pending == 1'b0);
        repeat (4) @(negedge clk);
        chk(n_stop == s0 + 1, "R9 stop condition seen", n_stop, s0 + 1);
        chk(scl_line && sda_line, "R9 lines released", {30'h0, scl_line, sda_line}, 32'h3);
        chk(status == 8'hF8 && !irq_flag, "R11 idle status after stop", {24'h0, status}, 32'hF8);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        logic [7:0] got;
        logic mack;
        bit frozen;
        int s0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'hF8, "R1 status", {24'h0, status}, 32'hF8);
        chk(!irq_flag && !start_pending && !stop_pending, "R1 flag/requests",
            {29'h0, irq_flag, start_pending, stop_pending}, 32'h0);
        chk(!scl_oe && !sda_oe, "R1 lines released", {30'h0, scl_oe, sda_oe}, 32'h0);

        // R2 start waits for a free bus
        slv_low = 1'b1;
        repeat (3) @(negedge clk);
        s0 = n_start;
        expect_status(8'h08, "R2 start status");
        pulse_start();
        repeat (6 * HALF) @(negedge clk);
        chk(!irq_flag && !sda_oe && start_pending, "R2 no start on busy bus",
            {29'h0, irq_flag, sda_oe, start_pending}, 32'h1);
        chk(status == 8'hF8, "R11 status while waiting", {24'h0, status}, 32'hF8);
        slv_low = 1'b0;
        s0 = n_start;
        wait_irq();
        chk(n_start == s0 + 1, "R2 start condition seen", n_start, s0 + 1);
        chk(start_pending == 1'b0, "R2 start request clears", {31'h0, start_pending}, 32'h0);

        // R7 stall holds the bus
        frozen = 1;
        for (int i = 0; i < 6 * HALF; i++) begin
            @(negedge clk);
            if (scl_line || !irq_flag || status != 8'h08) frozen = 0;
        end
        chk(frozen, "R7 SCL held low while flag set", {31'h0, frozen}, 32'h1);

        // R3 write address acked
        load(8'hA4);
        expect_status(8'h18, "R3 write address ack");
        slave_rx(1'b1, got);
        chk(got == 8'hA4, "R3 address bits on bus", {24'h0, got}, 32'hA4);
        chk(hi_w == 5 * HALF, "R10 SCL high width", hi_w, 5 * HALF);
        chk(lo_w == 5 * HALF, "R10 SCL low width", lo_w, 5 * HALF);

        // R5 data bytes
        load(8'h3C);
        expect_status(8'h28, "R5 data ack");
        slave_rx(1'b1, got);
        chk(got == 8'h3C, "R5 data bits", {24'h0, got}, 32'h3C);
        load(8'hC3);
        expect_status(8'h30, "R5 data nack");
        slave_rx(1'b0, got);
        chk(got == 8'hC3, "R5 data bits 2", {24'h0, got}, 32'hC3);
        do_stop();

        // R4 / R6 read transfer
        do_start("R2 start status 2");
        load(8'hA5);
        expect_status(8'h40, "R4 read address ack");
        slave_rx(1'b1, got);
        chk(got == 8'hA5, "R4 address bits", {24'h0, got}, 32'hA5);
        ack_en = 1'b1;
        expect_status(8'h50, "R6 read byte ack");
        slave_tx(8'h96, mack);
        chk(mack == 1'b0, "R6 master acknowledges", {31'h0, mack}, 32'h0);
        chk(rd_data == 8'h96, "R6 received byte", {24'h0, rd_data}, 32'h96);
        ack_en = 1'b0;
        expect_status(8'h58, "R6 read byte nack");
        slave_tx(8'h5A, mack);
        chk(mack == 1'b1, "R6 master not-acknowledges", {31'h0, mack}, 32'h1);
        chk(rd_data == 8'h5A, "R6 received byte 2", {24'h0, rd_data}, 32'h5A);
        do_stop();

        // R3 / R4 address nack
        do_start("R2 start status 3");
        load(8'hA4);
        expect_status(8'h20, "R3 write address nack");
        slave_rx(1'b0, got);
        do_stop();
        do_start("R2 start status 4");
        load(8'hA5);
        expect_status(8'h48, "R4 read address nack");
        slave_rx(1'b0, got);
        do_stop();

        // R8 arbitration loss on first address bit
        do_start("R2 start status 5");
        load(8'hA4);
        expect_status(8'h38, "R8 arbitration lost");
        slv_low = 1'b1;
        pulse_clr();
        wait_irq();
        repeat (2) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R8 master released lines", {30'h0, scl_oe, sda_oe}, 32'h0);
        slv_low = 1'b0;
        pulse_clr();
        @(negedge clk);
        chk(status == 8'hF8 && !irq_flag, "R11 status after clear", {24'h0, status}, 32'hF8);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_up();
    end
endmodule